// File: doc/BRIEF.md
# Sticky Saturation Overflow Status

This block sits at the output of a six-channel signed sample path. Each channel delivers a wide intermediate sample with a valid strobe. The block saturates that sample to the signed range of the output word and registers the result. It also records every clipping event in a sticky status register that a host reads over a small register bus. Channel index `i` (0 to 5) carries the channels A1, B1, A2, B2, A3 and B3 in that order. Status bit `i` belongs to channel `i`.

The host chooses between two interrupt styles.

- **Level mode:** the status bits hold across reads, and the interrupt stays high while any bit is set.
- **Edge mode:** a read of the status address returns the bits and clears them. The interrupt is a one-cycle pulse whenever a bit goes from 0 to 1.

The interrupt mask gates only the interrupt line. The status bits keep recording events while the mask is set, so the host can poll overflow instead of taking an interrupt. The register is read-only: the bus has no write path, so a write cannot alter it.

Top module: `sat_ovf_monitor`

## Requirements
- R1: A sample accepted with its valid bit appears on that channel's output slice on the next clock edge. A value above +0x7FFFFF becomes +0x7FFFFF, a value below -0x800000 becomes 0x800000, and an in-range value, including both limits, passes unchanged.
- R2: A clipped sample on channel `i` sets status bit `i` on the same edge that registers the output. Bit 0 is A1, bit 1 is B1, bit 2 is A2, bit 3 is B2, bit 4 is A3 and bit 5 is B3. A sample equal to a limit sets no bit.
- R3: A status bit that is 1 stays 1 after the overflow ends, until a clearing read.
- R4: A read with `rd_stb` high at address 0x2B returns the status in `rd_data` one cycle later, with bits 7:6 read as 0. In edge mode (`irq_edge`=1) that read clears all bits.
- R5: In level mode (`irq_edge`=0) a status read leaves the bits unchanged.
- R6: An overflow that arrives in the same cycle as a clearing read leaves its bit at 1 after the read.
- R7: `ovf_mask` has no effect on the status bits.
- R8: In level mode `ovf_irq` is high whenever any status bit is 1 and `ovf_mask` is 0. It is low whenever `ovf_mask` is 1.
- R9: In edge mode `ovf_irq` is high for exactly the one cycle after a clock edge on which some status bit went from 0 to 1, provided `ovf_mask` is 0.
- R10: A read of any address other than 0x2B returns 0 and clears nothing.
- R11: After reset all status bits, `rd_data`, `ovf_irq` and the output samples are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | NUM_CH*IN_W | Wide signed samples, channel i at bits [i*IN_W +: IN_W] |
| smp_vld | input | NUM_CH | Per-channel sample valid |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| irq_edge | input | 1 | 1 = edge interrupt mode (read clears), 0 = level mode |
| ovf_mask | input | 1 | 1 = overflow interrupt masked |
| smp_out | output | NUM_CH*OUT_W | Saturated samples, channel i at bits [i*OUT_W +: OUT_W] |
| smp_out_vld | output | NUM_CH | Per-channel output valid, one cycle after smp_vld |
| rd_data | output | 8 | Registered read data |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with its defaults: six channels, 28-bit inputs and 24-bit outputs. With these values the exact limits +0x7FFFFF and -0x800000, and the values one step beyond each limit, can all be driven. This shows clipping in both directions and the absence of a status bit exactly at full scale. With six channels every status bit can be set, so the full bit order can be checked, along with the zero padding in bits 7:6. Reads that coincide with new overflows on the same channel and on a different channel test the clear-versus-set priority in edge mode.

// File: rtl/sat_ovf_pkg.sv
package sat_ovf_pkg;

    localparam int STATUS_W = 8;
    localparam int ADDR_W   = 8;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'h2B;

    typedef enum logic {
        IRQ_LEVEL = 1'b0,
        IRQ_EDGE  = 1'b1
    } irq_mode_e;

    typedef struct packed {
        logic hit;   // read addressed to the status register
        logic clr;   // that read also clears the sticky bits
    } rd_ctl_t;

    function automatic rd_ctl_t decode_read(input logic stb,
                                            input logic [ADDR_W-1:0] addr,
                                            input irq_mode_e mode);
        rd_ctl_t r;
        r.hit = stb && (addr == STATUS_ADDR);
        r.clr = r.hit && (mode == IRQ_EDGE);
        return r;
    endfunction

endpackage

// File: rtl/sat_clip.sv
module sat_clip #(
    parameter int IN_W  = 28,
    parameter int OUT_W = 24
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout,
    output logic             clipped
);
    localparam int HEAD_W = IN_W - OUT_W + 1;

    logic [HEAD_W-1:0] head;
    logic [OUT_W-1:0]  pos_full;
    logic [OUT_W-1:0]  neg_full;

    assign head     = din[IN_W-1:OUT_W-1];
    assign pos_full = {1'b0, {(OUT_W-1){1'b1}}};
    assign neg_full = {1'b1, {(OUT_W-1){1'b0}}};

    always_comb begin
        clipped = !((&head) || !(|head));
        if (!clipped)
            dout = din[OUT_W-1:0];
        else if (din[IN_W-1])
            dout = neg_full;
        else
            dout = pos_full;
    end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] evt,
    input  logic              clr,
    output logic [NUM_CH-1:0] status_q,
    output logic              rise_q
);
    logic [NUM_CH-1:0] status_nxt;

    always_comb begin
        status_nxt = (clr ? '0 : status_q) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            rise_q   <= 1'b0;
        end else begin
            status_q <= status_nxt;
            rise_q   <= |(status_nxt & ~status_q);
        end
    end
endmodule

// File: rtl/sat_irq.sv
module sat_irq
    import sat_ovf_pkg::*;
(
    input  irq_mode_e mode,
    input  logic      mask,
    input  logic      any_set,
    input  logic      rise_q,
    output logic      irq
);
    always_comb begin
        if (mask)
            irq = 1'b0;
        else if (mode == IRQ_EDGE)
            irq = rise_q;
        else
            irq = any_set;
    end
endmodule

// File: rtl/sat_ovf_monitor.sv
module sat_ovf_monitor
    import sat_ovf_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int IN_W   = 28,
    parameter int OUT_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH*IN_W-1:0]  smp_in,
    input  logic [NUM_CH-1:0]       smp_vld,
    input  logic                    rd_stb,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    irq_edge,
    input  logic                    ovf_mask,
    output logic [NUM_CH*OUT_W-1:0] smp_out,
    output logic [NUM_CH-1:0]       smp_out_vld,
    output logic [STATUS_W-1:0]     rd_data,
    output logic                    ovf_irq
);
    irq_mode_e         mode;
    rd_ctl_t           rd_ctl;
    logic [NUM_CH-1:0] clip_hit;
    logic [NUM_CH-1:0] evt;
    logic [NUM_CH-1:0] status_q;
    logic              rise_q;

    assign mode   = irq_mode_e'(irq_edge);
    assign rd_ctl = decode_read(rd_stb, rd_addr, mode);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [OUT_W-1:0] sat_w;

        sat_clip #(.IN_W(IN_W), .OUT_W(OUT_W)) u_clip (
            .din     (smp_in[i*IN_W +: IN_W]),
            .dout    (sat_w),
            .clipped (clip_hit[i])
        );

        assign evt[i] = smp_vld[i] && clip_hit[i];

        always_ff @(posedge clk) begin
            if (rst)
                smp_out[i*OUT_W +: OUT_W] <= '0;
            else if (smp_vld[i])
                smp_out[i*OUT_W +: OUT_W] <= sat_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_out_vld <= '0;
            rd_data     <= '0;
        end else begin
            smp_out_vld <= smp_vld;
            rd_data     <= rd_ctl.hit ? STATUS_W'(status_q) : '0;
        end
    end

    sat_sticky #(.NUM_CH(NUM_CH)) u_sticky (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr      (rd_ctl.clr),
        .status_q (status_q),
        .rise_q   (rise_q)
    );

    sat_irq u_irq (
        .mode    (mode),
        .mask    (ovf_mask),
        .any_set (|status_q),
        .rise_q  (rise_q),
        .irq     (ovf_irq)
    );
endmodule

// File: rtl/sat_ovf_monitor_chk.sv
module sat_ovf_monitor_chk
    import sat_ovf_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                rd_stb,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic                irq_edge,
    input logic                ovf_mask,
    input logic [NUM_CH-1:0]   smp_vld,
    input logic [STATUS_W-1:0] rd_data,
    input logic                ovf_irq,
    input logic [NUM_CH-1:0]   status_q
);
    logic edge_clear;
    assign edge_clear = rd_stb && (rd_addr == STATUS_ADDR) && irq_edge;

    // R2
    status_src_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(smp_vld)) == '0));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_clear |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R4
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[STATUS_W-1:NUM_CH] == '0);

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_mask |-> !ovf_irq);

    // R9
    edge_irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_edge && ovf_irq) |-> (status_q != '0));
endmodule

bind sat_ovf_monitor sat_ovf_monitor_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (rd_stb),
    .rd_addr  (rd_addr),
    .irq_edge (irq_edge),
    .ovf_mask (ovf_mask),
    .smp_vld  (smp_vld),
    .rd_data  (rd_data),
    .ovf_irq  (ovf_irq),
    .status_q (status_q)
);

// File: tb/sat_ovf_monitor_tb.sv
module sat_ovf_monitor_tb;
    localparam int NUM_CH = 6;
    localparam int IN_W   = 28;
    localparam int OUT_W  = 24;
    localparam logic [7:0] ST_ADDR = 8'h2B;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [NUM_CH*IN_W-1:0]  smp_in = '0;
    logic [NUM_CH-1:0]       smp_vld = '0;
    logic                    rd_stb = 1'b0;
    logic [7:0]              rd_addr = '0;
    logic                    irq_edge = 1'b0;
    logic                    ovf_mask = 1'b1;
    logic [NUM_CH*OUT_W-1:0] smp_out;
    logic [NUM_CH-1:0]       smp_out_vld;
    logic [7:0]              rd_data;
    logic                    ovf_irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    sat_ovf_monitor #(.NUM_CH(NUM_CH), .IN_W(IN_W), .OUT_W(OUT_W)) u_dut (
        .clk(clk), .rst(rst), .smp_in(smp_in), .smp_vld(smp_vld),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .irq_edge(irq_edge),
        .ovf_mask(ovf_mask), .smp_out(smp_out), .smp_out_vld(smp_out_vld),
        .rd_data(rd_data), .ovf_irq(ovf_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_vld = '0; rd_stb = 1'b0; smp_in = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_smp(input int ch, input int val);
        smp_in[ch*IN_W +: IN_W] = IN_W'(val);
        smp_vld[ch] = 1'b1;
    endtask

    // one clock with whatever is staged, then clear strobes
    task automatic step();
        @(negedge clk);
        smp_vld = '0;
        rd_stb  = 1'b0;
    endtask

    task automatic push(input int ch, input int val);
        set_smp(ch, val);
        step();
    endtask

    task automatic read_at(input logic [7:0] a);
        rd_stb = 1'b1; rd_addr = a;
        step();
    endtask

    function automatic logic [31:0] out_of(input int ch);
        return 32'(smp_out[ch*OUT_W +: OUT_W]);
    endfunction

    task automatic t_reset();
        chk("R11 rd_data", 32'(rd_data), 0);
        chk("R11 irq", 32'(ovf_irq), 0);
        chk("R11 smp_out", 32'(|smp_out), 0);
        read_at(ST_ADDR);
        chk("R11 status", 32'(rd_data), 0);
    endtask

    task automatic t_clip_level();
        do_reset();
        irq_edge = 1'b0; ovf_mask = 1'b1;
        push(0, 32'h0800000);
        chk("R1 pos clip", out_of(0), 32'h7FFFFF);
        chk("R1 out valid", 32'(smp_out_vld), 32'h01);
        push(1, -8388609);
        chk("R1 neg clip", out_of(1), 32'h800000);
        push(2, 32'h7FFFFF);
        chk("R1 pos limit", out_of(2), 32'h7FFFFF);
        push(3, -8388608);
        chk("R1 neg limit", out_of(3), 32'h800000);
        push(4, 32'h123);
        chk("R1 small", out_of(4), 32'h123);
        read_at(ST_ADDR);
        chk("R2 map/limits, R7 masked", 32'(rd_data), 32'h03);
        read_at(ST_ADDR);
        chk("R5 level read keeps", 32'(rd_data), 32'h03);
        push(0, 5);
        repeat (3) step();
        read_at(ST_ADDR);
        chk("R3 sticky", 32'(rd_data), 32'h03);
    endtask

    task automatic t_all_bits();
        do_reset();
        irq_edge = 1'b1; ovf_mask = 1'b1;
        for (int c = 0; c < NUM_CH; c++) set_smp(c, (c % 2 == 0) ? 32'h4000000 : -67108864);
        step();
        read_at(ST_ADDR);
        chk("R2 all bits R4 reserved zero", 32'(rd_data), 32'h3F);
        read_at(ST_ADDR);
        chk("R4 edge clear", 32'(rd_data), 0);
    endtask

    task automatic t_edge_irq();
        do_reset();
        irq_edge = 1'b1; ovf_mask = 1'b0;
        push(5, 32'h0900000);
        chk("R9 pulse high", 32'(ovf_irq), 1);
        step();
        chk("R9 pulse one cycle", 32'(ovf_irq), 0);
        push(5, 32'h0900000);
        chk("R9 no pulse when already set", 32'(ovf_irq), 0);
        read_at(ST_ADDR);
        chk("R4 read B3", 32'(rd_data), 32'h20);
        read_at(ST_ADDR);
        chk("R4 cleared", 32'(rd_data), 0);
        push(5, 32'h0900000);
        chk("R9 pulse after clear", 32'(ovf_irq), 1);
    endtask

    task automatic t_simul();
        do_reset();
        irq_edge = 1'b1; ovf_mask = 1'b1;
        push(0, 32'h0800000);
        set_smp(4, 32'h0800000);
        read_at(ST_ADDR);
        chk("R6 read value", 32'(rd_data), 32'h01);
        read_at(ST_ADDR);
        chk("R6 other ch kept", 32'(rd_data), 32'h10);
        push(0, 32'h0800000);
        set_smp(0, 32'h0800000);
        read_at(ST_ADDR);
        chk("R6 same ch read", 32'(rd_data), 32'h01);
        read_at(ST_ADDR);
        chk("R6 same ch kept", 32'(rd_data), 32'h01);
    endtask

    task automatic t_level_irq();
        do_reset();
        irq_edge = 1'b0; ovf_mask = 1'b0;
        step();
        chk("R8 idle low", 32'(ovf_irq), 0);
        push(2, -16777216);
        chk("R8 high", 32'(ovf_irq), 1);
        repeat (3) step();
        chk("R8 held", 32'(ovf_irq), 1);
        read_at(ST_ADDR);
        chk("R8 held after read", 32'(ovf_irq), 1);
        ovf_mask = 1'b1;
        #1;
        chk("R8 masked", 32'(ovf_irq), 0);
        ovf_mask = 1'b0;
    endtask

    task automatic t_addr();
        do_reset();
        irq_edge = 1'b1; ovf_mask = 1'b1;
        push(3, 32'h0A00000);
        read_at(8'h2C);
        chk("R10 other addr zero", 32'(rd_data), 0);
        read_at(8'h2A);
        chk("R10 other addr zero 2", 32'(rd_data), 0);
        read_at(ST_ADDR);
        chk("R10 no clear by other addr", 32'(rd_data), 32'h08);
    endtask

    bit done = 1'b0;

    initial begin
        do_reset();
        t_reset();
        t_clip_level();
        t_all_bits();
        t_edge_irq();
        t_simul();
        t_level_irq();
        t_addr();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule